// File: doc/BRIEF.md
# Searchable FIFO with Flush

This block is a synchronous first-in first-out queue placed between two pipeline stages. A typical use is between the decode and execute stages of a small processor. The producer pushes payload words, and the consumer reads the oldest word and pops it. Every method follows a guarded handshake. Each method has a ready output, and each action method also has an enable input. An action takes effect only when its enable is high and its ready is high. The queue also has a flush that empties it in one cycle. A taken branch uses the flush to drop the work queued behind it.

The queue also answers a search question within the same cycle. It reports whether any entry currently held has a key field equal to a presented key. The key is a slice of the payload, for example the destination register index of a queued instruction. The upstream stage uses this answer to stall on a read-after-write hazard. Entries that have been popped or flushed no longer match. The payload width, key width, key position and depth are all parameters.

Top module: `search_fifo`

## Requirements
- R1: While reset is low at a clock edge, and afterwards until the next enqueue, the queue is empty: `push_rdy`=1, `pop_rdy`=0, `head_rdy`=0, `probe_hit`=0.
- R2: `push_rdy` is low exactly when the queue holds DEPTH entries (default 4). A push fired into a non-full queue without a pop raises the occupancy by one.
- R3: `pop_rdy` and `head_rdy` are both high exactly when the queue holds at least one entry.
- R4: `head_data` always presents the oldest held entry. Entries leave in the order they entered.
- R5: When a push and a pop both fire in the same cycle, both take effect and the occupancy does not change. On a full queue only the pop fires, because `push_rdy` is low. On an empty queue only the push fires, because `pop_rdy` is low.
- R6: An enable given while its ready is low is ignored. A push into a full queue changes neither the contents nor the order. A pop from an empty queue leaves it empty.
- R7: `flush_en` empties the queue at the next edge. It wins over a push or pop enabled in the same cycle, and neither of them takes effect.
- R8: `probe_hit` is combinational. It is 1 exactly when some held entry has payload bits [KEY_LSB +: KEY_W] (default bits [4:0]) equal to `probe_key`. Popped or flushed entries never match.
- R9: `flush_rdy` and `probe_rdy` are always high. Flush and search may be used in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_en | input | 1 | Enqueue enable |
| push_data | input | PAY_W | Payload to enqueue |
| push_rdy | output | 1 | Enqueue may be taken (not full) |
| pop_en | input | 1 | Dequeue enable |
| pop_rdy | output | 1 | Dequeue may be taken (not empty) |
| head_data | output | PAY_W | Oldest held payload |
| head_rdy | output | 1 | `head_data` is meaningful (not empty) |
| flush_en | input | 1 | Empty the queue |
| flush_rdy | output | 1 | Flush may be taken (always 1) |
| probe_key | input | KEY_W | Key searched among held entries |
| probe_hit | output | 1 | Some held entry carries `probe_key` |
| probe_rdy | output | 1 | Search result is valid (always 1) |

## Verification
A single scripted sequence exercises several paths. It fills the queue, pushes into a full queue, swaps on a full queue and on a partly filled queue, drains to empty and pops an empty queue. Each of these separates the occupancy rules from one another. Searches use keys that match the oldest entry, the youngest entry, a slot that has just been popped, and a key that is absent. A key that lingers in a slot after a pop exposes a search that looks at storage instead of at held entries. A flush combined with a push, and another combined with a pop, shows whether the flush really has priority. A fill from reset checks the full boundary one entry at a time, and a reset in mid-operation checks that the queue returns to its empty state.

// File: rtl/sfifo_pkg.sv
// Package: shared types for the searchable FIFO.
// Assumes: nothing; holds only the occupancy-change encoding.
package sfifo_pkg;

    // How the occupancy moves in one cycle.
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_UP   = 2'd1,
        OCC_DOWN = 2'd2,
        OCC_ZERO = 2'd3
    } occ_step_e;

endpackage

// File: rtl/sfifo_ctrl.sv
// Module: sfifo_ctrl
// Keeps the write and read pointers and the occupancy, and derives the ready
// outputs. It also gates the enables into the fire strobes used by storage.
// Assumes: flush has priority over push and pop; DEPTH >= 2.
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic             flush_en,
    output logic             push_rdy,
    output logic             pop_rdy,
    output logic             wr_fire,
    output logic             rd_fire,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] occ
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_OCC  = CNT_W'(DEPTH);

    occ_step_e step;

    // Ready outputs follow from the occupancy.
    always_comb begin
        push_rdy = (occ != FULL_OCC);
        pop_rdy  = (occ != '0);
    end

    // Gate the enables by ready and by flush.
    always_comb begin
        wr_fire = push_en && push_rdy && !flush_en;
        rd_fire = pop_en  && pop_rdy  && !flush_en;
    end

    // Pick how the occupancy moves this cycle.
    always_comb begin
        if (flush_en)                step = OCC_ZERO;
        else if (wr_fire && !rd_fire) step = OCC_UP;
        else if (rd_fire && !wr_fire) step = OCC_DOWN;
        else                          step = OCC_HOLD;
    end

    // Advance the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else if (step == OCC_ZERO) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (wr_fire) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + PTR_W'(1);
            if (rd_fire) rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + PTR_W'(1);
            case (step)
                OCC_UP:   occ <= occ + CNT_W'(1);
                OCC_DOWN: occ <= occ - CNT_W'(1);
                default:  occ <= occ;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth.
    p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_OCC);

    // R2: a lone push into a non-full queue adds exactly one entry.
    p_push_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_rdy && !pop_en && !flush_en) |=> (occ == $past(occ) + CNT_W'(1)));

    // R5: a push and a pop firing together keep the occupancy.
    p_swap_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && rd_fire) |=> $stable(occ));

    // R6: a push offered to a full queue alone changes nothing.
    p_full_push_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !push_rdy && !pop_en && !flush_en) |=> (occ == FULL_OCC));

    // R6: a pop offered to an empty queue alone leaves it empty.
    p_empty_pop_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !pop_rdy && !push_en && !flush_en) |=> (occ == '0));

    // R7: a flush empties the queue at the next edge.
    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (occ == '0 && !pop_rdy));

endmodule

// File: rtl/sfifo_store.sv
// Module: sfifo_store
// Holds the payload slots and one held-entry flag per slot. It serves the
// oldest payload and searches every held slot for the key.
// Assumes: the write and read fires never target the same slot in one cycle.
module sfifo_store #(
    parameter int DEPTH   = 4,
    parameter int PAY_W   = 16,
    parameter int KEY_W   = 5,
    parameter int KEY_LSB = 0,
    parameter int PTR_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PAY_W-1:0] wr_data,
    input  logic             rd_fire,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic             flush,
    input  logic [KEY_W-1:0] probe_key,
    output logic [PAY_W-1:0] head_data,
    output logic [DEPTH-1:0] held,
    output logic             hit
);

    logic [PAY_W-1:0] slot [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Capture the payload when this slot is written.
        always_ff @(posedge clk) begin
            if (wr_fire && wr_ptr == PTR_W'(i)) slot[i] <= wr_data;
        end

        // Track whether this slot holds a live entry.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)                     held[i] <= 1'b0;
            else if (wr_fire && wr_ptr == PTR_W'(i)) held[i] <= 1'b1;
            else if (rd_fire && rd_ptr == PTR_W'(i)) held[i] <= 1'b0;
        end

        // Compare the key field of a live slot with the probe.
        always_comb begin
            match[i] = held[i] && (slot[i][KEY_LSB +: KEY_W] == probe_key);
        end
    end

    // Present the oldest payload and reduce the matches.
    always_comb begin
        head_data = slot[rd_ptr];
        hit       = |match;
    end

    // R8: a hit needs at least one live slot.
    p_hit_needs_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (held != '0));

    // R4: the slot being read out is live.
    p_read_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |-> held[rd_ptr]);

endmodule

// File: rtl/search_fifo.sv
// Module: search_fifo
// A FIFO with a guarded handshake, a single-cycle flush and a combinational
// key search over the entries it holds.
// Assumes: the key is the payload slice [KEY_LSB +: KEY_W]; DEPTH >= 2.
module search_fifo #(
    parameter int DEPTH   = 4,
    parameter int PAY_W   = 16,
    parameter int KEY_W   = 5,
    parameter int KEY_LSB = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [PAY_W-1:0] push_data,
    output logic             push_rdy,
    input  logic             pop_en,
    output logic             pop_rdy,
    output logic [PAY_W-1:0] head_data,
    output logic             head_rdy,
    input  logic             flush_en,
    output logic             flush_rdy,
    input  logic [KEY_W-1:0] probe_key,
    output logic             probe_hit,
    output logic             probe_rdy
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_fire, rd_fire;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] occ;
    logic [DEPTH-1:0] held;

    sfifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .flush_en (flush_en),
        .push_rdy (push_rdy),
        .pop_rdy  (pop_rdy),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .occ      (occ)
    );

    sfifo_store #(.DEPTH(DEPTH), .PAY_W(PAY_W), .KEY_W(KEY_W),
                  .KEY_LSB(KEY_LSB), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .wr_ptr    (wr_ptr),
        .wr_data   (push_data),
        .rd_fire   (rd_fire),
        .rd_ptr    (rd_ptr),
        .flush     (flush_en),
        .probe_key (probe_key),
        .head_data (head_data),
        .held      (held),
        .hit       (probe_hit)
    );

    // Read-oldest shares the not-empty guard; flush and search never block.
    always_comb begin
        head_rdy  = pop_rdy;
        flush_rdy = 1'b1;
        probe_rdy = 1'b1;
    end

    // R3: the live-slot flags agree with the occupancy counter.
    p_held_matches_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(held) == int'(occ));

    // R1: the cycle after reset the queue is empty.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (!pop_rdy && push_rdy && !probe_hit));

endmodule

// File: tb/tb_search_fifo.sv
module tb_search_fifo;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_en, pop_en, flush_en;
    logic [15:0] push_data;
    logic [4:0]  probe_key;
    logic        push_rdy, pop_rdy, head_rdy, flush_rdy, probe_hit, probe_rdy;
    logic [15:0] head_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    search_fifo dut (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_data(push_data), .push_rdy(push_rdy),
        .pop_en(pop_en), .pop_rdy(pop_rdy),
        .head_data(head_data), .head_rdy(head_rdy),
        .flush_en(flush_en), .flush_rdy(flush_rdy),
        .probe_key(probe_key), .probe_hit(probe_hit), .probe_rdy(probe_rdy)
    );

    typedef struct packed {
        logic        psh;
        logic [15:0] dat;
        logic        pop;
        logic        fl;
        logic [4:0]  key;
        logic        x_prdy;
        logic        x_nempty;
        logic [15:0] x_head;
        logic        x_hit;
        logic [3:0]  rq;
    } vec_t;

    // Expected values are those seen before the edge that applies the row.
    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 16'hA101, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd1}, // R1 empty, push A
        '{1'b1, 16'hB202, 1'b0, 1'b0, 5'd1, 1'b1, 1'b1, 16'hA101, 1'b1, 4'd8}, // R8 oldest key
        '{1'b1, 16'hC303, 1'b0, 1'b0, 5'd2, 1'b1, 1'b1, 16'hA101, 1'b1, 4'd8}, // R8 youngest key
        '{1'b1, 16'hD404, 1'b0, 1'b0, 5'd9, 1'b1, 1'b1, 16'hA101, 1'b0, 4'd8}, // R8 absent key
        '{1'b1, 16'hE505, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1, 16'hA101, 1'b0, 4'd2}, // R2 full, R6 push ignored
        '{1'b1, 16'hE505, 1'b1, 1'b0, 5'd5, 1'b0, 1'b1, 16'hA101, 1'b0, 4'd6}, // R6 contents kept; R5 full swap = pop only
        '{1'b1, 16'hE505, 1'b1, 1'b0, 5'd1, 1'b1, 1'b1, 16'hB202, 1'b0, 4'd5}, // R5 swap, popped key gone
        '{1'b0, 16'h0000, 1'b1, 1'b0, 5'd5, 1'b1, 1'b1, 16'hC303, 1'b1, 4'd4}, // R4 order after swap
        '{1'b0, 16'h0000, 1'b1, 1'b0, 5'd3, 1'b1, 1'b1, 16'hD404, 1'b0, 4'd4}, // R4 order
        '{1'b0, 16'h0000, 1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 16'hE505, 1'b0, 4'd4}, // R4 last entry
        '{1'b0, 16'h0000, 1'b1, 1'b0, 5'd5, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd6}, // R6 pop on empty
        '{1'b1, 16'hF606, 1'b0, 1'b0, 5'd6, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd3}, // R3 still empty
        '{1'b1, 16'hA101, 1'b0, 1'b1, 5'd6, 1'b1, 1'b1, 16'hF606, 1'b1, 4'd7}, // R7 flush beats push
        '{1'b1, 16'hB202, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd7}, // R7 emptied; R5 empty swap = push only
        '{1'b0, 16'h0000, 1'b0, 1'b0, 5'd2, 1'b1, 1'b1, 16'hB202, 1'b1, 4'd5}, // R5 push taken on empty
        '{1'b0, 16'h0000, 1'b1, 1'b1, 5'd2, 1'b1, 1'b1, 16'hB202, 1'b1, 4'd7}, // R7 flush with pop
        '{1'b0, 16'h0000, 1'b0, 1'b0, 5'd2, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd7}  // R7 flushed key gone
    };

    // Compare one observed value with its expectation and tally it.
    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive inputs after a falling edge; sampling is 1 ns before the rise.
    task automatic drive(input logic p, input logic [15:0] d, input logic q,
                         input logic f, input logic [4:0] k);
        @(negedge clk);
        push_en = p; push_data = d; pop_en = q; flush_en = f; probe_key = k;
        #4;
    endtask

    // Check the empty state (R1).
    task automatic chk_empty(input string tag);
        chk("R1", {tag, " push_rdy"}, 16'(push_rdy), 16'd1);
        chk("R1", {tag, " pop_rdy"},  16'(pop_rdy),  16'd0);
        chk("R1", {tag, " head_rdy"}, 16'(head_rdy), 16'd0);
        chk("R1", {tag, " probe_hit"}, 16'(probe_hit), 16'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        push_en = 1'b0; pop_en = 1'b0; flush_en = 1'b0;
        push_data = '0; probe_key = '0;
        repeat (2) @(posedge clk);
        drive(1'b0, 16'h0, 1'b0, 1'b0, 5'd0);
        chk_empty("in reset");
        rst_n = 1'b1;

        // R9: flush and search are always ready.
        chk("R9", "flush_rdy", 16'(flush_rdy), 16'd1);
        chk("R9", "probe_rdy", 16'(probe_rdy), 16'd1);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            string rq;
            drive(TBL[i].psh, TBL[i].dat, TBL[i].pop, TBL[i].fl, TBL[i].key);
            rq = $sformatf("R%0d", TBL[i].rq);
            chk(rq, $sformatf("row %0d push_rdy", i), 16'(push_rdy), 16'(TBL[i].x_prdy));
            chk(rq, $sformatf("row %0d pop_rdy", i),  16'(pop_rdy),  16'(TBL[i].x_nempty));
            chk(rq, $sformatf("row %0d head_rdy", i), 16'(head_rdy), 16'(TBL[i].x_nempty));
            chk(rq, $sformatf("row %0d probe_hit", i), 16'(probe_hit), 16'(TBL[i].x_hit));
            if (TBL[i].x_nempty)
                chk(rq, $sformatf("row %0d head_data", i), head_data, TBL[i].x_head);
        end

        // R2: fill from empty, push_rdy high until the fourth entry lands.
        for (int j = 0; j < 4; j++) begin
            drive(1'b1, 16'h1000 + 16'(j), 1'b0, 1'b0, 5'd3);
            chk("R2", $sformatf("fill %0d push_rdy", j), 16'(push_rdy), 16'd1);
        end
        drive(1'b0, 16'h0, 1'b0, 1'b0, 5'd3);
        chk("R2", "full push_rdy", 16'(push_rdy), 16'd0);
        chk("R8", "key 3 in slot 3", 16'(probe_hit), 16'd1);
        chk("R4", "head after fill", head_data, 16'h1000);

        // R1: reset mid-operation returns to empty.
        rst_n = 1'b0;
        drive(1'b0, 16'h0, 1'b0, 1'b0, 5'd3);
        drive(1'b0, 16'h0, 1'b0, 1'b0, 5'd3);
        rst_n = 1'b1;
        chk_empty("after mid reset");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule